// File: doc/BRIEF.md
# Receive Idle Timeout Timer

This block watches a receive FIFO and raises a one-cycle event when characters have sat in it, unread, for a programmed number of serial bit times. The link feeding the FIFO has no baud rate of its own. The block therefore builds one from a 16-bit step value, so that software sees the same timeout as on a conventional serial port.

A phase accumulator adds the step value once per clock, and each carry out of the accumulator is an oversample tick. Sixteen ticks make one bit time, and whole bit times are counted against a 24-bit limit. The count restarts whenever the FIFO is read, whenever a character is pushed into it, whenever it is empty, and whenever the feature is disabled.

All pins are plain control and status levels or strobes. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `rx_idle_timeout`

## Requirements
- R1: While reset is asserted, and afterwards until a timeout condition is met, `timeout_o` is low.
- R2: A 17-bit accumulator is cleared by reset. On each clock it loads its low 16 bits plus `step_i`. Bit 16 of the accumulator is the oversample tick, so the tick appears in the cycle after the addition that carried. A step of zero produces no ticks.
- R3: One bit time equals 16 oversample ticks. The tick counter within a bit is cleared whenever the count restarts, so a partial bit time is discarded.
- R4: The count restarts, and no event can fire in the following cycle, in any cycle where `rd_strobe_i` or `wr_strobe_i` is high, `fifo_empty_i` is high, or `enable_i` is low. A restart takes priority over a bit tick in the same cycle.
- R5: `timeout_o` is high for exactly one cycle. That cycle follows the bit tick on which the number of whole bit times since the last restart reaches or passes `limit_i`.
- R6: After firing, the block stays silent until the next restart. After a restart it can fire again.
- R7: A `limit_i` of zero never produces an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 16 | Rate step added into the accumulator each clock |
| limit_i | input | 24 | Timeout length in bit times; zero disables firing |
| enable_i | input | 1 | Timeout feature enable |
| fifo_empty_i | input | 1 | Receive FIFO holds no characters |
| rd_strobe_i | input | 1 | A character was read from the FIFO this cycle |
| wr_strobe_i | input | 1 | A character was pushed into the FIFO this cycle |
| timeout_o | output | 1 | One-cycle timeout event |

## Verification
The bench builds the block with its default parameters: a 16-bit step, a 24-bit limit and 16 ticks per bit time. With these defaults, step values of 0x8000, 0x4000 and 0xFFFF give bit times of about 32, 64 and 16 clocks. Small limits therefore bring the full count, the event, the silence after it and a second firing within a few hundred cycles. Restart strobes spaced shorter than the programmed period show that a read or a push holds the event off. Zero step, zero limit, an empty FIFO and a disabled feature each show that no event fires.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  localparam int unsigned STEP_W_DEF  = 16;
  localparam int unsigned LIMIT_W_DEF = 24;
  localparam int unsigned OSR_DEF     = 16;

  // Reasons that restart the idle count.
  typedef struct packed {
    logic rd;
    logic wr;
    logic empty;
    logic off;
  } restart_t;

  function automatic logic any_restart(restart_t r);
    return r.rd | r.wr | r.empty | r.off;
  endfunction
endpackage

// File: rtl/rxto_nco.sv
module rxto_nco #(
  parameter int unsigned STEP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STEP_W-1:0] step_i,
  output logic              tick_o
);
  localparam int unsigned ACC_W = STEP_W + 1;

  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= {1'b0, acc_q[STEP_W-1:0]} + {1'b0, step_i};
  end

  assign tick_o = acc_q[STEP_W];

  // A zero step cannot carry out of the accumulator.
  assert_zero_step_no_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == '0) |=> !tick_o);
endmodule

// File: rtl/rxto_bit_div.sv
module rxto_bit_div #(
  parameter int unsigned OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic bit_tick_o
);
  localparam int unsigned PRE_W = (OSR < 2) ? 1 : $clog2(OSR);
  localparam logic [PRE_W-1:0] LAST = PRE_W'(OSR - 1);

  generate
    if (OSR < 2) begin : g_bad_osr
      $error("rxto_bit_div: OSR must be at least 2");
    end
  endgenerate

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clr_i)   pre_q <= '0;
    else if (tick_i)  pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end

  assign bit_tick_o = tick_i && (pre_q == LAST);

  // Phase within a bit moves only on a tick or a restart.
  assert_phase_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(pre_q));
  // A restart always returns the phase to zero.
  assert_phase_cleared_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pre_q == '0));
endmodule

// File: rtl/rxto_idle_cnt.sv
module rxto_idle_cnt #(
  parameter int unsigned LIMIT_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               bit_tick_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic               event_o
);
  logic [LIMIT_W-1:0] cnt_q;
  logic               fired_q;
  logic [LIMIT_W:0]   cnt_next;
  logic               advance;
  logic               reach;

  assign cnt_next = {1'b0, cnt_q} + 1'b1;
  assign advance  = !clr_i && bit_tick_i && !fired_q;
  assign reach    = advance && (limit_i != '0) && (cnt_next >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      event_o <= 1'b0;
    end else begin
      event_o <= reach;
      if (clr_i) begin
        cnt_q   <= '0;
        fired_q <= 1'b0;
      end else begin
        if (advance && (cnt_q != '1)) cnt_q <= cnt_next[LIMIT_W-1:0];
        if (reach)                    fired_q <= 1'b1;
      end
    end
  end

  assert_single_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> !event_o);
  assert_silent_after_fire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fired_q && !clr_i) |=> !event_o);
  assert_zero_limit_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> ($past(limit_i) != '0));
  assert_fire_on_bit_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> $past(bit_tick_i));
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
  import rxto_pkg::*;
#(
  parameter int unsigned STEP_W  = STEP_W_DEF,
  parameter int unsigned LIMIT_W = LIMIT_W_DEF,
  parameter int unsigned OSR     = OSR_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STEP_W-1:0]  step_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               enable_i,
  input  logic               fifo_empty_i,
  input  logic               rd_strobe_i,
  input  logic               wr_strobe_i,
  output logic               timeout_o
);
  restart_t why;
  logic     restart;
  logic     os_tick;
  logic     bit_tick;

  assign why.rd    = rd_strobe_i;
  assign why.wr    = wr_strobe_i;
  assign why.empty = fifo_empty_i;
  assign why.off   = !enable_i;
  assign restart   = any_restart(why);

  rxto_nco #(.STEP_W(STEP_W)) u_nco (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_i),
    .tick_o (os_tick)
  );

  rxto_bit_div #(.OSR(OSR)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (os_tick),
    .clr_i      (restart),
    .bit_tick_o (bit_tick)
  );

  rxto_idle_cnt #(.LIMIT_W(LIMIT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (restart),
    .bit_tick_i (bit_tick),
    .limit_i    (limit_i),
    .event_o    (timeout_o)
  );

  // An event needs a cycle with data waiting, enabled and no FIFO traffic.
  assert_no_fire_after_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> $past(enable_i && !fifo_empty_i && !rd_strobe_i && !wr_strobe_i));
  assert_bit_needs_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick |-> os_tick);
endmodule

// File: tb/test_rx_idle_timeout.sv
module test_rx_idle_timeout;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] step = '0;
  logic [23:0] limit = '0;
  logic        en = 1'b0;
  logic        empty = 1'b1;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic        timeout;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  int cyc = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_idle_timeout i_rx_idle_timeout (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .limit_i(limit),
    .enable_i(en), .fifo_empty_i(empty), .rd_strobe_i(rd), .wr_strobe_i(wr),
    .timeout_o(timeout)
  );

  // Reference model written from R2..R7; predicts the cycle of each event.
  logic [16:0] m_acc;
  logic [3:0]  m_pre;
  logic [23:0] m_cnt;
  logic        m_fired;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc <= '0; m_pre <= '0; m_cnt <= '0; m_fired <= 1'b0; cyc <= 0;
    end else begin
      logic clr, btick;
      cyc   <= cyc + 1;
      m_acc <= {1'b0, m_acc[15:0]} + {1'b0, step};
      clr   = rd || wr || empty || !en;
      btick = m_acc[16] && (m_pre == 4'd15);
      if (clr) m_pre <= '0;
      else if (m_acc[16]) m_pre <= m_pre + 4'd1;
      if (clr) begin
        m_cnt <= '0; m_fired <= 1'b0;
      end else if (btick && !m_fired) begin
        m_cnt <= m_cnt + 24'd1;
        if (limit != 0 && ({1'b0, m_cnt} + 25'd1) >= {1'b0, limit}) begin
          m_fired <= 1'b1;
          exp_q.push_back(cyc + 1);
        end
      end
    end
  end

  // Monitor: compares each event against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_q.size() > 0 && exp_q[0] < cyc) begin
        checks++; failures++;
        $display("FAIL R5 missed event: actual none expected cycle %0d", exp_q[0]);
        void'(exp_q.pop_front());
      end
      if (timeout) begin
        pulses++;
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R5 unexpected event: actual cycle %0d expected none", cyc);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (e != cyc) begin
            failures++;
            $display("FAIL R3/R5 event timing: actual cycle %0d expected %0d", cyc, e);
          end
        end
      end
    end
  end

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic run(input logic [15:0] s, input logic [23:0] lim, input bit e,
                     input bit emp, input int n, input int rd_per, input int wr_per,
                     input int exp_pulses, input string req);
    @(negedge clk);
    empty = 1'b1; rd = 1'b0; wr = 1'b0;
    repeat (3) @(negedge clk);
    pulses = 0;
    step = s; limit = lim; en = e; empty = emp;
    for (int i = 0; i < n; i++) begin
      rd = (rd_per != 0) && (i % rd_per == rd_per - 1);
      wr = (wr_per != 0) && (i % wr_per == wr_per - 1);
      @(negedge clk);
    end
    rd = 1'b0; wr = 1'b0; empty = 1'b1;
    repeat (3) @(negedge clk);
    check(pulses == exp_pulses, req, pulses, exp_pulses);
    check(exp_q.size() == 0, {req, " pending"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(timeout == 1'b0, "R1 in reset", timeout, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(timeout == 1'b0, "R1 after reset", timeout, 0);

    run(16'h8000, 24'd3, 1, 0, 400, 0, 0, 1, "R5 R6 basic fire once");
    run(16'h4000, 24'd2, 1, 0, 300, 0, 0, 1, "R3 slower step");
    run(16'hFFFF, 24'd5, 1, 0, 200, 0, 0, 1, "R3 fast step");
    run(16'h8000, 24'd0, 1, 0, 400, 0, 0, 0, "R7 zero limit");
    run(16'h0000, 24'd1, 1, 0, 300, 0, 0, 0, "R2 zero step");
    run(16'h8000, 24'd1, 0, 0, 300, 0, 0, 0, "R4 disabled");
    run(16'h8000, 24'd1, 1, 1, 300, 0, 0, 0, "R4 fifo empty");
    run(16'h8000, 24'd2, 1, 0, 400, 50, 0, 0, "R4 reads hold off");
    run(16'h8000, 24'd2, 1, 0, 400, 0, 50, 0, "R4 pushes hold off");
    run(16'h8000, 24'd1, 1, 0, 300, 150, 0, 2, "R6 refire after read");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule